// File: doc/BRIEF.md
# Serial-in parallel-out shift register with storage register

The block is a serial-in, parallel-out shift stage that feeds a storage register of the same width, 8 bits by default. Serial data moves into the shift stage one bit per rising edge of the shift clock and does not change polarity on the way. A rising edge of the separate storage clock copies the whole shift stage onto the parallel outputs. The parallel outputs therefore stay steady while a new word is shifted in, and all of them change together.

Each stage has its own active-low asynchronous clear, and each clear affects only its own stage. The top bit of the shift stage is presented on a serial output. Several instances can be chained through that output, and the chain then behaves as one longer shift register. If both clocks are driven from a single signal, the parallel outputs always show the shift contents from one edge earlier.

Top module: `sipo_store_reg`

## Requirements
- R1: On each rising edge of `sh_clk_i`, bit 0 of the shift stage takes `ser_i` and every bit n for n of 1 or more takes the old value of bit n-1, with no inversion.
- R2: On each rising edge of `st_clk_i`, `par_o` takes the current shift stage contents, with bit n of `par_o` equal to shift bit n.
- R3: `ser_o` equals the top shift bit, bit WIDTH-1. It changes only on shift clock edges or on a shift clear, and a storage clock edge leaves it unchanged.
- R4: When both clocks rise together, `par_o` takes the shift contents from before that edge, so it lags the shift stage by exactly one shift.
- R5: While `sh_rst_ni` is low, the shift stage, and with it `ser_o`, is forced to zero at once and held there regardless of `sh_clk_i`. `par_o` is not affected.
- R6: While `st_rst_ni` is low, `par_o` is forced to zero at once and held there regardless of `st_clk_i`. The shift stage is not affected.
- R7: A storage clock edge with no shift clock edge since the previous storage edge leaves `par_o` unchanged.
- R8: When `ser_o` of one instance drives `ser_i` of a second instance and both share the clocks, the pair acts as one 2*WIDTH-bit register, with the second instance holding the upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sh_clk_i | input | 1 | Shift clock, rising edge |
| sh_rst_ni | input | 1 | Shift stage clear, active low, asynchronous |
| ser_i | input | 1 | Serial data into shift bit 0 |
| st_clk_i | input | 1 | Storage clock, rising edge |
| st_rst_ni | input | 1 | Storage register clear, active low, asynchronous |
| par_o | output | WIDTH | Parallel outputs from the storage register |
| ser_o | output | 1 | Top shift bit, for chaining |

## Verification
A shift edge changes `ser_o` within the same edge, with one register in the path. A storage edge changes `par_o` within its own edge, and both clears act with no clock at all. The bench therefore raises a clock or a clear, waits a few nanoseconds with every clock low again, and only then compares the outputs with its 16-bit reference model of two chained instances. Nothing is sampled at a clock edge. In tied-clock operations the model loads its storage copy before it updates its shift copy, which gives the one-edge lag that R4 requires.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned DefWidth = 8;
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned WIDTH = sipo_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[WIDTH-2:0], ser_i};
  end

  assign q_o = q;
endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
  parameter int unsigned WIDTH = sipo_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // one flop per bit, each cleared on its own
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d_i[b];
    end
    assign q_o[b] = q;
  end
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int unsigned WIDTH = sipo_pkg::DefWidth
) (
  input  logic             sh_clk_i,
  input  logic             sh_rst_ni,
  input  logic             ser_i,
  input  logic             st_clk_i,
  input  logic             st_rst_ni,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  localparam int unsigned MsbIdx = WIDTH - 1;

  logic [WIDTH-1:0] sh_q;

  sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk_i  (sh_clk_i),
    .rst_ni (sh_rst_ni),
    .ser_i  (ser_i),
    .q_o    (sh_q)
  );

  sipo_store_stage #(.WIDTH(WIDTH)) u_store (
    .clk_i  (st_clk_i),
    .rst_ni (st_rst_ni),
    .d_i    (sh_q),
    .q_o    (par_o)
  );

  assign ser_o = sh_q[MsbIdx];
endmodule

// File: rtl/sipo_store_reg_chk.sv
module sipo_store_reg_chk #(
  parameter int unsigned WIDTH = sipo_pkg::DefWidth
) (
  input logic             sh_clk_i,
  input logic             sh_rst_ni,
  input logic             ser_i,
  input logic             st_clk_i,
  input logic             st_rst_ni,
  input logic [WIDTH-1:0] par_o,
  input logic             ser_o,
  input logic [WIDTH-1:0] sh_q
);
  // set once a shift edge has been seen since the last clear
  logic sh_seen;
  always_ff @(posedge sh_clk_i or negedge sh_rst_ni) begin
    if (!sh_rst_ni) sh_seen <= 1'b0;
    else            sh_seen <= 1'b1;
  end

  // R1
  shift_move_chk: assert property (@(posedge sh_clk_i) disable iff (!sh_rst_ni)
    sh_seen |-> (sh_q[WIDTH-1:1] == $past(sh_q[WIDTH-2:0])) && (sh_q[0] == $past(ser_i)));

  // R3
  cascade_bit_chk: assert property (@(posedge sh_clk_i) disable iff (!sh_rst_ni)
    sh_seen |-> ser_o == $past(sh_q[WIDTH-2]));

  // R5
  shift_clear_hold_chk: assert property (@(posedge st_clk_i) disable iff (!st_rst_ni)
    !sh_rst_ni |-> (sh_q == '0) && !ser_o);

  // R6
  store_clear_hold_chk: assert property (@(posedge sh_clk_i) disable iff (!sh_rst_ni)
    !st_rst_ni |-> par_o == '0);
endmodule

bind sipo_store_reg sipo_store_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .sh_clk_i  (sh_clk_i),
  .sh_rst_ni (sh_rst_ni),
  .ser_i     (ser_i),
  .st_clk_i  (st_clk_i),
  .st_rst_ni (st_rst_ni),
  .par_o     (par_o),
  .ser_o     (ser_o),
  .sh_q      (sh_q)
);

// File: tb/sipo_store_reg_bench.sv
`timescale 1ns/1ps
module sipo_store_reg_bench;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sh_clk = 1'b0, st_clk = 1'b0, sh_rst_n = 1'b1, st_rst_n = 1'b1, ser = 1'b0;
  logic [W-1:0] par_lo, par_hi;
  logic ser_lo, ser_hi;

  sipo_store_reg #(.WIDTH(W)) u_sipo_store_reg (
    .sh_clk_i(sh_clk), .sh_rst_ni(sh_rst_n), .ser_i(ser),
    .st_clk_i(st_clk), .st_rst_ni(st_rst_n), .par_o(par_lo), .ser_o(ser_lo));

  sipo_store_reg #(.WIDTH(W)) u_sipo_store_reg_hi (
    .sh_clk_i(sh_clk), .sh_rst_ni(sh_rst_n), .ser_i(ser_lo),
    .st_clk_i(st_clk), .st_rst_ni(st_rst_n), .par_o(par_hi), .ser_o(ser_hi));

  int total = 0, bad = 0;
  logic [2*W-1:0] sh_m = '0, st_m = '0;
  bit done = 0;

  function automatic logic [2*W-1:0] shifted(logic [2*W-1:0] v, logic d);
    return {v[2*W-2:0], d};
  endfunction

  task automatic chk(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " par"}, {par_hi, par_lo}, st_m);
    chk({req, " ser_lo"}, {15'd0, ser_lo}, {15'd0, sh_m[W-1]});
    chk({req, " ser_hi"}, {15'd0, ser_hi}, {15'd0, sh_m[2*W-1]});
  endtask

  task automatic do_shift(logic d);
    ser = d; #2 sh_clk = 1'b1; #3 sh_clk = 1'b0; #5;
    if (sh_rst_n) sh_m = shifted(sh_m, d);
  endtask

  task automatic do_store();
    #2 st_clk = 1'b1; #3 st_clk = 1'b0; #5;
    if (st_rst_n) st_m = sh_m;
  endtask

  task automatic do_both(logic d);
    ser = d; #2 begin sh_clk = 1'b1; st_clk = 1'b1; end
    #3 begin sh_clk = 1'b0; st_clk = 1'b0; end #5;
    st_m = sh_m;
    sh_m = shifted(sh_m, d);
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 100000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<100000", n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [2*W-1:0] pat;
    logic [W-1:0] keep;
    int unsigned r;
    r = $urandom(32'h5eed_1234);
    #1 sh_rst_n = 1'b0; st_rst_n = 1'b0;
    #10 chk_all("R5 R6 reset");
    sh_rst_n = 1'b1; st_rst_n = 1'b1; #10;

    // R1 R2 R8: directed 16-bit pattern, msb first
    pat = 16'hA5C3;
    for (int i = 2*W-1; i >= 0; i--) do_shift(pat[i]);
    chk_all("R3 R8 before store");
    do_store();
    chk("R1 R2 R8 pattern", {par_hi, par_lo}, pat);

    // R7: repeated store with no shift
    do_store(); chk_all("R7 store twice");
    do_store(); chk_all("R7 store thrice");

    // R3: storage edge does not move ser_o
    do_shift(1'b1); do_store(); chk_all("R3 after store");

    // R4: tied clocks lag by one
    for (int i = 0; i < 20; i++) begin
      do_both(1'(i % 3 == 0));
      chk_all("R4 tied");
    end

    // R5: shift clear holds despite clocks, leaves storage alone
    do_shift(1'b1); do_store();
    keep = par_lo;
    sh_rst_n = 1'b0; #2;
    sh_m = '0;
    chk_all("R5 clear immediate");
    do_shift(1'b1); do_shift(1'b1);
    chk_all("R5 clear held");
    chk("R5 storage kept", {8'd0, par_lo}, {8'd0, keep});
    sh_rst_n = 1'b1; #5;
    do_store(); chk_all("R5 zeros stored");

    // R6: storage clear holds despite clocks, leaves shift alone
    for (int i = 0; i < 2*W; i++) do_shift(1'(i[0]));
    do_store();
    st_rst_n = 1'b0; #2;
    st_m = '0;
    chk_all("R6 clear immediate");
    do_store(); do_shift(1'b0);
    chk_all("R6 clear held");
    st_rst_n = 1'b1; #5;
    do_store(); chk_all("R6 shift kept");

    // random mix
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      case (r % 4)
        0, 1: do_shift(r[4]);
        2:    do_store();
        default: do_both(r[5]);
      endcase
      chk_all("R1 R2 R4 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule